// File: doc/BRIEF.md
# Time-Multiplexed Neural Network Inference Engine

This block evaluates small fixed-point feed-forward networks for a resource manager that needs many performance predictions in a short time. One physical datapath with twelve inputs, four hidden units and one output unit is shared by sixteen virtual networks. Each virtual network has its own set of weights, and the engine picks the set for a query from the query's 4-bit tag. A new query may enter on every clock, so a full pass over all sixteen networks takes sixteen consecutive cycles.

Each query carries twelve signed Q8.8 inputs. Every unit adds a bias weight to the sum of its input products, saturates the total to 16 bits, and maps it through a 50-entry activation table. The four hidden activations feed the output unit in the same way. Tags are grouped in fours: the upper two bits name an application and the lower two bits name one of its four networks. An averaging stage collects the four results of an application and emits their mean.

Weights are written one word at a time through a write port that is honoured only while no query is in flight. The activation table has its own write port and is expected to be loaded before any queries are issued.

Top module: `nn_mux_engine`

## Requirements
- R1: Each unit's output is table[index(sat16(bias + sum of (x_k * w_k) >>> 8))], and the hidden layer's four outputs are the inputs of the output unit; all values are signed Q8.8.
- R2: Within a weight set, word h*13 is hidden unit h's bias and word h*13+1+k is its weight for input k (k = 0..11). Word 52 is the output bias and word 53+h is the output weight for hidden unit h. The set index is wr_set.
- R3: The bias enters each sum through its weight alone, with no input operand; with all other weights zero, the unit sum equals the bias weight.
- R4: The table index is (s >>> 6) + 25 for the saturated 16-bit sum s, clamped to 0 when below range and to 49 when above it.
- R5: The result for a query sampled at clock edge k appears on net_pred/net_tag with net_valid after edge k+15, carrying the query's tag, and net_valid stays low before that.
- R6: Queries issued on consecutive cycles each use the weight set chosen by their own tag, and each result emerges one per cycle in issue order.
- R7: An application result (app_id = tag[3:2]) is emitted one cycle after the fourth distinct member (tag[1:0]) of that application has returned. Its value is floor(sum of the members' latest values / 4). A member that returns twice before completion replaces its earlier value.
- R8: A weight write is ignored while busy is high or q_valid is asserted; busy is high after any edge that leaves a query in flight. A write made while idle changes later results.
- R9: After reset, busy, net_valid and app_valid are low.
- R10: Each product is the full signed 32-bit product of two Q8.8 values, arithmetically shifted right by 8 before summation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | 1 | Query present this cycle |
| q_tag | input | 4 | Virtual network index of the query |
| q_vec | input | 192 | Twelve Q8.8 inputs, input k at bits [16k+15:16k] |
| wr_en | input | 1 | Weight write request |
| wr_set | input | 4 | Weight set to write |
| wr_addr | input | 6 | Word within the set |
| wr_data | input | 16 | Weight value |
| lut_wr_en | input | 1 | Activation table write |
| lut_idx | input | 6 | Table entry, 0 to 49 |
| lut_data | input | 16 | Table value |
| busy | output | 1 | A query is in flight |
| net_valid | output | 1 | Per-network result valid |
| net_tag | output | 4 | Tag of that result |
| net_pred | output | 16 | Per-network prediction |
| app_valid | output | 1 | Application average valid |
| app_id | output | 2 | Application of the average |
| app_pred | output | 16 | Averaged prediction |

## Verification
A query sampled at edge k yields its per-network result after edge k+15 and any application average one edge later. The bench drives on falling edges and counts falling edges from the issue: it expects net_valid low on every intermediate falling edge and checks the value and tag on the sixteenth. It then checks the average, or its absence, on the seventeenth. In the burst tests issue and retirement overlap, so each cycle's check is tied to the query issued exactly sixteen cycles before.

// File: rtl/nn_pkg.sv
package nn_pkg;
  localparam int DW          = 16;
  localparam int FRAC        = 8;
  localparam int N_IN        = 12;
  localparam int N_HID       = 4;
  localparam int N_NET       = 16;
  localparam int NET_PER_APP = 4;
  localparam int LUT_N       = 50;
  localparam int IDX_SHIFT   = 6;
  localparam int ACC_W       = 36;
  localparam int MUL_ST      = 4;
  localparam int TREE_ST     = 3;

  localparam int TAG_W     = $clog2(N_NET);
  localparam int HID_TERMS = N_IN + 1;
  localparam int OUT_TERMS = N_HID + 1;
  localparam int OUT_BASE  = N_HID * HID_TERMS;
  localparam int W_PER_SET = OUT_BASE + OUT_TERMS;
  localparam int WADDR_W   = $clog2(W_PER_SET);
  localparam int LIDX_W    = $clog2(LUT_N);
  localparam int LUT_MID   = LUT_N / 2;
  localparam int N_APP     = N_NET / NET_PER_APP;
  localparam int MEM_W     = $clog2(NET_PER_APP);
  localparam int APP_W     = TAG_W - MEM_W;
  localparam int UNIT_LAT  = MUL_ST + TREE_ST;
  localparam int LAYER_LAT = UNIT_LAT + 1;
  localparam int LAT       = 2 * LAYER_LAT;
  localparam int SMAX      = 2 ** (DW - 1) - 1;

  function automatic logic [DW-1:0] sat_dw(input logic signed [ACC_W-1:0] a);
    if (a > ACC_W'(SMAX))
      return DW'(SMAX);
    else if (a < ACC_W'(-SMAX - 1))
      return DW'(-SMAX - 1);
    else
      return a[DW-1:0];
  endfunction

  function automatic logic [LIDX_W-1:0] lut_index(input logic signed [DW-1:0] s);
    logic signed [DW-1:0] q;
    q = s >>> IDX_SHIFT;
    if (q < DW'(-LUT_MID))
      return '0;
    else if (q > DW'(LUT_N - 1 - LUT_MID))
      return LIDX_W'(LUT_N - 1);
    else
      return LIDX_W'(q + DW'(LUT_MID));
  endfunction
endpackage

// File: rtl/nn_weight_store.sv
module nn_weight_store
  import nn_pkg::*;
(
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [TAG_W-1:0]              wr_set,
  input  logic [WADDR_W-1:0]            wr_addr,
  input  logic [DW-1:0]                 wr_data,
  input  logic [TAG_W-1:0]              hid_set,
  output logic [OUT_BASE*DW-1:0]        hid_w_flat,
  input  logic [TAG_W-1:0]              out_set,
  output logic [OUT_TERMS*DW-1:0]       out_w_flat
);
  logic [DW-1:0] mem_q [N_NET][W_PER_SET];
  logic          wr_hit;

  assign wr_hit = wr_en && (wr_addr < WADDR_W'(W_PER_SET));

  always_ff @(posedge clk) begin
    if (wr_hit) mem_q[wr_set][wr_addr] <= wr_data;
  end

  always_comb begin
    for (int j = 0; j < OUT_BASE; j++)
      hid_w_flat[j*DW +: DW] = mem_q[hid_set][j];
    for (int j = 0; j < OUT_TERMS; j++)
      out_w_flat[j*DW +: DW] = mem_q[out_set][OUT_BASE + j];
  end
endmodule

// File: rtl/nn_unit_pipe.sv
module nn_unit_pipe
  import nn_pkg::*;
#(
  parameter int NI = N_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [NI*DW-1:0]  x_flat,
  input  logic [NI*DW-1:0]  w_flat,
  input  logic [DW-1:0]     bias,
  output logic              out_vld,
  output logic [DW-1:0]     out_sum
);
  localparam int NT = NI + 1;
  localparam int G1 = (NT + 3) / 4;
  localparam int G2 = (G1 + 1) / 2;

  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic signed [2*DW-1:0]   wide_t;

  wide_t  xe_c   [NI];
  wide_t  we_c   [NI];
  wide_t  prod_c [NI];
  acc_t   term_c [NT];
  acc_t   mul_q  [MUL_ST][NT];
  acc_t   l1_c   [G1];
  acc_t   l1_q   [G1];
  acc_t   l2_c   [G2];
  acc_t   l2_q   [G2];
  acc_t   l3_c;
  logic [DW-1:0]       sum_q;
  logic [UNIT_LAT-1:0] vld_q;
  logic [UNIT_LAT-1:0] vld_d;

  // multiply and align, bias passes without a multiplier
  always_comb begin
    term_c[0] = acc_t'($signed(bias));
    for (int k = 0; k < NI; k++) begin
      xe_c[k]     = wide_t'($signed(x_flat[k*DW +: DW]));
      we_c[k]     = wide_t'($signed(w_flat[k*DW +: DW]));
      prod_c[k]   = xe_c[k] * we_c[k];
      term_c[k+1] = acc_t'(prod_c[k] >>> FRAC);
    end
  end

  // three-level reduction: groups of four, pairs, final
  always_comb begin
    for (int g = 0; g < G1; g++) begin
      l1_c[g] = '0;
      for (int j = 0; j < 4; j++)
        if (4*g + j < NT) l1_c[g] = l1_c[g] + mul_q[MUL_ST-1][4*g + j];
    end
    for (int g = 0; g < G2; g++) begin
      l2_c[g] = l1_q[2*g];
      if (2*g + 1 < G1) l2_c[g] = l2_c[g] + l1_q[2*g + 1];
    end
    l3_c = '0;
    for (int g = 0; g < G2; g++) l3_c = l3_c + l2_q[g];
  end

  assign vld_d = {vld_q[UNIT_LAT-2:0], in_vld};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (in_vld) mul_q[0] <= term_c;
    for (int s = 1; s < MUL_ST; s++)
      if (vld_q[s-1]) mul_q[s] <= mul_q[s-1];
    if (vld_q[MUL_ST-1]) l1_q  <= l1_c;
    if (vld_q[MUL_ST])   l2_q  <= l2_c;
    if (vld_q[MUL_ST+1]) sum_q <= sat_dw(l3_c);
  end

  assign out_vld = vld_q[UNIT_LAT-1];
  assign out_sum = sum_q;

  AST_UNIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld, UNIT_LAT)); // R5
endmodule

// File: rtl/nn_act_lut.sv
module nn_act_lut
  import nn_pkg::*;
#(
  parameter int NP = N_HID + 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LIDX_W-1:0] wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [NP-1:0]     rd_en,
  input  logic [NP*DW-1:0]  rd_sum,
  output logic [NP*DW-1:0]  rd_act
);
  logic [DW-1:0] tbl_q [LUT_N];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_idx < LIDX_W'(LUT_N))) tbl_q[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [LIDX_W-1:0] idx_c;
    logic [DW-1:0]     act_q;
    assign idx_c = lut_index(rd_sum[p*DW +: DW]);
    always_ff @(posedge clk) begin
      if (rd_en[p]) act_q <= tbl_q[idx_c];
    end
    assign rd_act[p*DW +: DW] = act_q;
  end
endmodule

// File: rtl/nn_app_avg.sv
module nn_app_avg
  import nn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [DW-1:0]    in_val,
  output logic             out_vld,
  output logic [APP_W-1:0] out_app,
  output logic [DW-1:0]    out_val
);
  localparam int SW = DW + MEM_W;

  logic [NET_PER_APP-1:0] seen_q [N_APP];
  logic [DW-1:0]          val_q  [N_APP][NET_PER_APP];
  logic [APP_W-1:0]       app_c;
  logic [MEM_W-1:0]       mem_c;
  logic [NET_PER_APP-1:0] mask_c;
  logic                   full_c;
  logic signed [SW-1:0]   sum_c;
  logic [DW-1:0]          avg_c;

  always_comb begin
    app_c  = in_tag[TAG_W-1:MEM_W];
    mem_c  = in_tag[MEM_W-1:0];
    mask_c = seen_q[app_c] | (NET_PER_APP'(1) << mem_c);
    full_c = &mask_c;
    sum_c  = '0;
    for (int m = 0; m < NET_PER_APP; m++) begin
      if (mem_c == MEM_W'(m)) sum_c = sum_c + SW'($signed(in_val));
      else                    sum_c = sum_c + SW'($signed(val_q[app_c][m]));
    end
    avg_c = DW'(sum_c >>> MEM_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      for (int a = 0; a < N_APP; a++) seen_q[a] <= '0;
    end else begin
      out_vld <= in_vld && full_c;
      if (in_vld) seen_q[app_c] <= full_c ? '0 : mask_c;
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) val_q[app_c][mem_c] <= in_val;
    if (in_vld && full_c) begin
      out_app <= app_c;
      out_val <= avg_c;
    end
  end

  AST_AVG_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld)); // R7
  AST_AVG_CLEARS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (seen_q[out_app] == '0)); // R7
endmodule

// File: rtl/nn_mux_engine.sv
module nn_mux_engine
  import nn_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 q_valid,
  input  logic [3:0]           q_tag,
  input  logic [191:0]         q_vec,
  input  logic                 wr_en,
  input  logic [3:0]           wr_set,
  input  logic [5:0]           wr_addr,
  input  logic [15:0]          wr_data,
  input  logic                 lut_wr_en,
  input  logic [5:0]           lut_idx,
  input  logic [15:0]          lut_data,
  output logic                 busy,
  output logic                 net_valid,
  output logic [3:0]           net_tag,
  output logic [15:0]          net_pred,
  output logic                 app_valid,
  output logic [1:0]           app_id,
  output logic [15:0]          app_pred
);
  localparam int NRD     = N_HID + 1;
  localparam int HID_DONE = UNIT_LAT - 1;
  localparam int OUT_IN   = LAYER_LAT - 1;
  localparam int OUT_DONE = LAYER_LAT + UNIT_LAT - 1;

  logic [LAT-1:0]        vld_q;
  logic [LAT-1:0]        vld_d;
  logic [TAG_W-1:0]      tag_q [LAT];
  logic                  wr_take;
  logic [OUT_BASE*DW-1:0]  hid_w_flat;
  logic [OUT_TERMS*DW-1:0] out_w_flat;
  logic [N_HID-1:0]      hid_vld;
  logic [N_HID*DW-1:0]   hid_sum;
  logic                  out_vld;
  logic [DW-1:0]         out_sum;
  logic [NRD-1:0]        rd_en;
  logic [NRD*DW-1:0]     rd_sum;
  logic [NRD*DW-1:0]     rd_act;

  // in-flight tracking and tag pipeline
  assign vld_d = {vld_q[LAT-2:0], q_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (q_valid) tag_q[0] <= q_tag;
    for (int s = 1; s < LAT; s++)
      if (vld_q[s-1]) tag_q[s] <= tag_q[s-1];
  end

  assign busy    = |vld_q;
  assign wr_take = wr_en && !busy && !q_valid;

  nn_weight_store u_wts (
    .clk        (clk),
    .wr_en      (wr_take),
    .wr_set     (wr_set),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .hid_set    (q_tag),
    .hid_w_flat (hid_w_flat),
    .out_set    (tag_q[OUT_IN]),
    .out_w_flat (out_w_flat)
  );

  for (genvar h = 0; h < N_HID; h++) begin : g_hid
    logic [N_IN*DW-1:0] w_row;
    always_comb begin
      for (int k = 0; k < N_IN; k++)
        w_row[k*DW +: DW] = hid_w_flat[(h*HID_TERMS + 1 + k)*DW +: DW];
    end
    nn_unit_pipe #(.NI(N_IN)) u_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (q_valid),
      .x_flat  (q_vec),
      .w_flat  (w_row),
      .bias    (hid_w_flat[(h*HID_TERMS)*DW +: DW]),
      .out_vld (hid_vld[h]),
      .out_sum (hid_sum[h*DW +: DW])
    );
  end

  nn_unit_pipe #(.NI(N_HID)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (vld_q[OUT_IN]),
    .x_flat  (rd_act[N_HID*DW-1:0]),
    .w_flat  (out_w_flat[OUT_TERMS*DW-1:DW]),
    .bias    (out_w_flat[DW-1:0]),
    .out_vld (out_vld),
    .out_sum (out_sum)
  );

  assign rd_en  = {vld_q[OUT_DONE], {N_HID{vld_q[HID_DONE]}}};
  assign rd_sum = {out_sum, hid_sum};

  nn_act_lut #(.NP(NRD)) u_lut (
    .clk     (clk),
    .wr_en   (lut_wr_en),
    .wr_idx  (lut_idx),
    .wr_data (lut_data),
    .rd_en   (rd_en),
    .rd_sum  (rd_sum),
    .rd_act  (rd_act)
  );

  assign net_valid = vld_q[LAT-1];
  assign net_tag   = tag_q[LAT-1];
  assign net_pred  = rd_act[N_HID*DW +: DW];

  nn_app_avg u_avg (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (net_valid),
    .in_tag  (net_tag),
    .in_val  (net_pred),
    .out_vld (app_valid),
    .out_app (app_id),
    .out_val (app_pred)
  );

  AST_HID_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    hid_vld == {N_HID{vld_q[HID_DONE]}}); // R6
  AST_OUT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == vld_q[OUT_DONE]); // R5
  AST_BUSY_AFTER_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> busy); // R8
  AST_TAG_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    net_valid |-> (net_tag == $past(q_tag, 16))); // R5
endmodule

// File: tb/sim_nn_mux_engine.sv
module sim_nn_mux_engine;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         q_valid;
  logic [3:0]   q_tag;
  logic [191:0] q_vec;
  logic         wr_en;
  logic [3:0]   wr_set;
  logic [5:0]   wr_addr;
  logic [15:0]  wr_data;
  logic         lut_wr_en;
  logic [5:0]   lut_idx;
  logic [15:0]  lut_data;
  logic         busy, net_valid, app_valid;
  logic [3:0]   net_tag;
  logic [15:0]  net_pred, app_pred;
  logic [1:0]   app_id;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  int w_m [16][57];
  int lut_m [50];
  int bt_tag [16];
  int bt_vec [16][12];
  int bt_exp [16];
  int av_seen [4];
  int av_val [4][4];
  bit pa_vld;
  int pa_id, pa_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  nn_mux_engine u0 (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_tag(q_tag), .q_vec(q_vec),
    .wr_en(wr_en), .wr_set(wr_set), .wr_addr(wr_addr), .wr_data(wr_data),
    .lut_wr_en(lut_wr_en), .lut_idx(lut_idx), .lut_data(lut_data),
    .busy(busy), .net_valid(net_valid), .net_tag(net_tag), .net_pred(net_pred),
    .app_valid(app_valid), .app_id(app_id), .app_pred(app_pred)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic int sat16(input longint a);
    if (a > 32767) return 32767;
    if (a < -32768) return -32768;
    return int'(a);
  endfunction

  function automatic int lidx(input int s);
    int q;
    q = s >>> 6;
    if (q < -25) return 0;
    if (q > 24) return 49;
    return q + 25;
  endfunction

  function automatic int unit_eval(input int n, input int base, input int cnt, input int xs [12]);
    longint acc;
    acc = w_m[n][base];
    for (int k = 0; k < cnt; k++)
      acc += (longint'(xs[k]) * longint'(w_m[n][base+1+k])) >>> 8;
    return lut_m[lidx(sat16(acc))];
  endfunction

  function automatic int net_model(input int n, input int qi);
    int xs [12];
    int hs [12];
    for (int k = 0; k < 12; k++) begin
      xs[k] = bt_vec[qi][k];
      hs[k] = 0;
    end
    for (int h = 0; h < 4; h++) hs[h] = unit_eval(n, h*13, 12, xs);
    return unit_eval(n, 52, 4, hs);
  endfunction

  task automatic av_step(input int tag, input int val);
    int a, m, sum;
    a = tag / 4;
    m = tag % 4;
    av_val[a][m] = val;
    av_seen[a] = av_seen[a] | (1 << m);
    pa_vld = 0;
    if (av_seen[a] == 15) begin
      sum = av_val[a][0] + av_val[a][1] + av_val[a][2] + av_val[a][3];
      pa_vld = 1;
      pa_id = a;
      pa_val = sum >>> 2;
      av_seen[a] = 0;
    end
  endtask

  // ---------------- drivers ----------------
  task automatic wr_weight(input int n, input int j, input int v);
    wr_en = 1; wr_set = 4'(n); wr_addr = 6'(j); wr_data = 16'(v);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic fill_vec(input int qi, input int seed);
    for (int k = 0; k < 12; k++) bt_vec[qi][k] = (((seed*13 + k*7) % 41) - 20) * 16;
  endtask

  task automatic drive_query(input int qi);
    q_valid = 1;
    q_tag = 4'(bt_tag[qi]);
    for (int k = 0; k < 12; k++) q_vec[k*16 +: 16] = 16'(bt_vec[qi][k]);
  endtask

  task automatic check_app(input string req);
    chk(app_valid == pa_vld, req, "app_valid", int'(app_valid), int'(pa_vld));
    if (pa_vld && app_valid) begin
      chk(int'(app_id) == pa_id, req, "app_id", int'(app_id), pa_id);
      chk(int'($signed(app_pred)) == pa_val, req, "app_pred", int'($signed(app_pred)), pa_val);
    end
  endtask

  // issue n back-to-back queries and check each result on its exact cycle
  task automatic run_burst(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      drive_query(i);
      @(negedge clk);
    end
    q_valid = 0;
    for (int c = n; c < 16; c++) begin
      chk(net_valid == 1'b0, "R5", "early net_valid", int'(net_valid), 0);
      @(negedge clk);
    end
    pa_vld = 0;
    for (int i = 0; i < n; i++) begin
      check_app(req);
      chk(net_valid == 1'b1, req, "net_valid", int'(net_valid), 1);
      chk(int'(net_tag) == bt_tag[i], req, "net_tag", int'(net_tag), bt_tag[i]);
      chk(int'($signed(net_pred)) == bt_exp[i], req, "net_pred", int'($signed(net_pred)), bt_exp[i]);
      av_step(bt_tag[i], bt_exp[i]);
      @(negedge clk);
    end
    check_app(req);
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(busy == 1'b0, "R9", "busy after reset", int'(busy), 0);
    chk(net_valid == 1'b0, "R9", "net_valid after reset", int'(net_valid), 0);
    chk(app_valid == 1'b0, "R9", "app_valid after reset", int'(app_valid), 0);
  endtask

  task automatic t_load;
    for (int i = 0; i < 50; i++) begin
      lut_m[i] = (i - 25) * 12;
      lut_wr_en = 1; lut_idx = 6'(i); lut_data = 16'(lut_m[i]);
      @(negedge clk);
    end
    lut_wr_en = 0;
    for (int n = 0; n < 16; n++)
      for (int j = 0; j < 57; j++) begin
        w_m[n][j] = (((n*37 + j*11 + 5) % 61) - 30) * 8;
        wr_weight(n, j, w_m[n][j]);
      end
  endtask

  task automatic t_single;
    // R1 R2 R10: one query, full two-layer evaluation
    bt_tag[0] = 3;
    fill_vec(0, 3);
    bt_exp[0] = net_model(3, 0);
    run_burst(1, "R1");
  endtask

  task automatic t_burst;
    // R6: sixteen consecutive queries, each with its own weight set; R7 averages
    for (int i = 0; i < 16; i++) begin
      bt_tag[i] = i;
      fill_vec(i, 20 + i);
      bt_exp[i] = net_model(i, i);
    end
    run_burst(16, "R6");
  endtask

  task automatic t_dup;
    // R7: member 1 of application 1 returns twice, the later value counts
    bt_tag[0] = 4; bt_tag[1] = 5; bt_tag[2] = 5; bt_tag[3] = 6; bt_tag[4] = 7;
    for (int i = 0; i < 5; i++) begin
      fill_vec(i, 50 + 3*i);
      bt_exp[i] = net_model(bt_tag[i], i);
    end
    run_burst(5, "R7");
  endtask

  task automatic t_clamp;
    // R3 R4: output unit driven only by its bias weight, saturating both ways
    wr_weight(9, 52, 32767); w_m[9][52] = 32767;
    for (int h = 0; h < 4; h++) begin
      wr_weight(9, 53 + h, 0); w_m[9][53 + h] = 0;
    end
    bt_tag[0] = 9;
    fill_vec(0, 7);
    bt_exp[0] = lut_m[49];
    run_burst(1, "R4");
    wr_weight(9, 52, -32768); w_m[9][52] = -32768;
    bt_exp[0] = lut_m[0];
    run_burst(1, "R4");
    // R3: bias 64 gives sum 64 -> index 26
    wr_weight(9, 52, 64); w_m[9][52] = 64;
    bt_exp[0] = lut_m[26];
    run_burst(1, "R3");
  endtask

  task automatic t_busy_write;
    int exp0;
    // R8: a write in the issue cycle and one during flight are both ignored
    bt_tag[0] = 5;
    fill_vec(0, 11);
    exp0 = net_model(5, 0);
    drive_query(0);
    wr_en = 1; wr_set = 4'd5; wr_addr = 6'd52; wr_data = 16'h7FFF;
    @(negedge clk);
    q_valid = 0;
    wr_set = 4'd5; wr_addr = 6'd53; wr_data = 16'h8000;
    chk(busy == 1'b1, "R8", "busy in flight", int'(busy), 1);
    @(negedge clk);
    wr_en = 0;
    for (int c = 2; c < 16; c++) @(negedge clk);
    chk(int'($signed(net_pred)) == exp0 && net_valid, "R8", "in-flight result", int'($signed(net_pred)), exp0);
    av_step(5, exp0);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R8", "busy drained", int'(busy), 0);
    bt_exp[0] = net_model(5, 0);
    run_burst(1, "R8");
    // idle write takes effect
    wr_weight(5, 52, 256); w_m[5][52] = 256;
    bt_exp[0] = net_model(5, 0);
    run_burst(1, "R8");
  endtask

  initial begin
    rst_n = 0; q_valid = 0; q_tag = '0; q_vec = '0;
    wr_en = 0; wr_set = '0; wr_addr = '0; wr_data = '0;
    lut_wr_en = 0; lut_idx = '0; lut_data = '0;
    for (int a = 0; a < 4; a++) begin
      av_seen[a] = 0;
      for (int m = 0; m < 4; m++) av_val[a][m] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_single();
    t_burst();
    t_dup();
    t_clamp();
    t_busy_write();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule